// File: doc/BRIEF.md
# Converter Serial Port Sequencer

This block is the device-side controller of a delta-sigma converter's serial port. It moves through three phases. While a conversion runs, the data line reports a busy flag. After the conversion, the block parks and the flag reads as ready. Once the host starts clocking, the block shifts the latched result out. The analog modulator and the decimation filter sit outside the block. They are represented by a one-cycle conversion-done strobe, which carries the result word with it.

The serial clock has two sources. With the clock-source select low, the host drives the serial clock. With it high, the block makes its own serial clock from the system clock and drives it out. Chip select does two jobs. It gates the data driver, and its release during a transfer cancels the transfer and restarts conversion. All port inputs are sampled on the system clock. Edges on chip select and on the serial clock are found by comparing each sample with the one before it.

Top module: `adc_serial_port`

## Requirements
- R1: While `rst` is high, `conv_start` is 1, `sck_out` is 0 and the block is in the converting phase. `conv_start` drops at the first clock edge after reset is released. A conversion is then in progress, so with `cs_n` low `sdo` reads 1.
- R2: `sdo_oe` is 1 exactly when `cs_n` is 0 (`sdo` is treated as high impedance otherwise).
- R3: In the converting phase `sdo` is 1. A `conv_done` strobe latches `result_in` and moves the block to the sleep phase, where `sdo` is 0 from the next cycle.
- R4: The block stays in sleep while `cs_n` is high, whatever the serial clock does. In external clock mode (`sck_internal`=0), it leaves sleep only on a rising serial clock edge seen while `cs_n` is low.
- R5: On entering data output, `sdo` carries bit RESULT_W-1 of the latched word. Each falling serial clock edge moves it on to the next lower bit, so the word leaves MSB first.
- R6: The RESULT_W-th falling edge ends the transfer. The block returns to converting and pulses `conv_start`.
- R7: A low-to-high change of `cs_n` during data output cancels the transfer, pulses `conv_start` and returns the block to converting. The next result is then read in full.
- R8: In internal clock mode, `sck_oe` is 1 and `sck_out` toggles every SCK_DIV/2 system clocks, but only in data output with `cs_n` low. It is 0 in every other case, including the cycle after any cycle with `cs_n` high.
- R9: In internal clock mode, `cs_n` low in sleep enters data output with no host edge, and the whole word arrives on the generated clock.
- R10: A `conv_done` strobe outside the converting phase is ignored, and the latched word is unchanged.
- R11: Every `conv_start` pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck_in | input | 1 | Serial clock from the host (external mode) |
| sck_internal | input | 1 | 1 selects the internally generated serial clock |
| conv_done | input | 1 | One-cycle end-of-conversion strobe |
| result_in | input | RESULT_W | Conversion result, valid with `conv_done` |
| sdo | output | 1 | Serial data / busy flag |
| sdo_oe | output | 1 | Driver enable for `sdo` |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Driver enable for `sck_out` |
| conv_start | output | 1 | One-cycle request to begin a conversion |

## Verification
The bench builds the block with its defaults, RESULT_W=32 and SCK_DIV=8. The 32-bit word makes the bit counter run up to its all-ones last index, 31, so the end-of-word decision sits at the top of the counter. The divider of 8 gives a generated clock with a four-cycle half period. This is long enough to measure, and to check that data moves only on its falling half. Both clock sources, cancellation partway through a word and an ignored strobe in sleep are each reached within a few thousand cycles.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DOUT  = 2'd2
  } sp_state_t;
endpackage

// File: rtl/adc_sp_edge.sv
// Single-edge detector on a sampled level; RISING picks the edge polarity.
module adc_sp_edge #(
  parameter bit RST_VAL = 1'b0,
  parameter bit RISING  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= din;
  end

  generate
    if (RISING) begin : g_rise
      assign pulse = din & ~prev;
    end else begin : g_fall
      assign pulse = ~din & prev;
    end
  endgenerate
endmodule

// File: rtl/adc_sp_sckgen.sv
// Divides the system clock for the serial clock; held low while not running.
module adc_sp_sckgen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck
);
  localparam int HALF = (DIV / 2 > 1) ? DIV / 2 : 1;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TERM = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (cnt == TERM) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/adc_sp_shifter.sv
// Result holding register, shifted toward the MSB end one bit per step.
module adc_sp_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)        word <= '0;
    else if (load)  word <= din;
    else if (shift) word <= {word[W-2:0], 1'b0};
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RESULT_W = 32,
  parameter int SCK_DIV  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                sck_in,
  input  logic                sck_internal,
  input  logic                conv_done,
  input  logic [RESULT_W-1:0] result_in,
  output logic                sdo,
  output logic                sdo_oe,
  output logic                sck_out,
  output logic                sck_oe,
  output logic                conv_start
);
  import adc_sp_pkg::*;

  localparam int CNT_W = (RESULT_W > 1) ? $clog2(RESULT_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(RESULT_W - 1);

  sp_state_t           state, state_nx;
  logic                start_nx;
  logic [CNT_W-1:0]    bit_cnt;
  logic [RESULT_W-1:0] word;
  logic                sck_eff, sck_rise, sck_fall, cs_rise;
  logic                gen_run, load_en, shift_en;

  assign gen_run = (state == ST_DOUT) && !cs_n && sck_internal;

  adc_sp_sckgen #(.DIV(SCK_DIV)) i_sckgen (
    .clk(clk), .rst(rst), .run(gen_run), .sck(sck_out)
  );

  assign sck_eff = sck_internal ? sck_out : sck_in;

  adc_sp_edge #(.RST_VAL(1'b0), .RISING(1'b1)) i_sck_rise (
    .clk(clk), .rst(rst), .din(sck_eff), .pulse(sck_rise)
  );
  adc_sp_edge #(.RST_VAL(1'b0), .RISING(1'b0)) i_sck_fall (
    .clk(clk), .rst(rst), .din(sck_eff), .pulse(sck_fall)
  );
  adc_sp_edge #(.RST_VAL(1'b1), .RISING(1'b1)) i_cs_rise (
    .clk(clk), .rst(rst), .din(cs_n), .pulse(cs_rise)
  );

  assign load_en  = (state == ST_CONV) && conv_done;
  assign shift_en = (state == ST_DOUT) && sck_fall && !cs_rise;

  adc_sp_shifter #(.W(RESULT_W)) i_shifter (
    .clk(clk), .rst(rst), .load(load_en), .din(result_in),
    .shift(shift_en), .word(word)
  );

  always_comb begin
    state_nx = state;
    start_nx = 1'b0;
    case (state)
      ST_CONV: begin
        if (conv_done) state_nx = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (!cs_n && (sck_internal || sck_rise)) state_nx = ST_DOUT;
      end
      ST_DOUT: begin
        if (cs_rise) begin
          state_nx = ST_CONV;
          start_nx = 1'b1;
        end else if (sck_fall && (bit_cnt == LAST_BIT)) begin
          state_nx = ST_CONV;
          start_nx = 1'b1;
        end
      end
      default: begin
        state_nx = ST_CONV;
        start_nx = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_CONV;
      conv_start <= 1'b1;
      bit_cnt    <= '0;
    end else begin
      state      <= state_nx;
      conv_start <= start_nx;
      if (state == ST_SLEEP && state_nx == ST_DOUT) bit_cnt <= '0;
      else if (shift_en)                             bit_cnt <= bit_cnt + CNT_W'(1);
    end
  end

  always_comb begin
    case (state)
      ST_CONV:  sdo = 1'b1;
      ST_SLEEP: sdo = 1'b0;
      default:  sdo = word[RESULT_W-1];
    endcase
  end

  assign sdo_oe = !cs_n;
  assign sck_oe = sck_internal;
endmodule

// File: rtl/adc_sp_checker.sv
module adc_sp_checker
  import adc_sp_pkg::*;
#(
  parameter int RESULT_W = 32,
  parameter int CNT_W    = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                cs_n,
  input logic                conv_done,
  input logic [RESULT_W-1:0] result_in,
  input logic                sck_out,
  input logic                conv_start,
  input sp_state_t           state,
  input logic [CNT_W-1:0]    bit_cnt,
  input logic [RESULT_W-1:0] word,
  input logic                sck_fall,
  input logic                cs_rise
);
  p_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV && conv_done) |=> (state == ST_SLEEP && word == $past(result_in)));

  p_sleep_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && cs_n) |=> (state == ST_SLEEP));

  p_last_bit_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DOUT && sck_fall && !cs_rise && bit_cnt == CNT_W'(RESULT_W - 1))
    |=> (conv_start && state == ST_CONV));

  p_abort_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DOUT && cs_rise) |=> (conv_start && state == ST_CONV));

  p_sck_idle_r8: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !sck_out);

  p_ignore_done_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && conv_done) |=> $stable(word));

  p_start_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
endmodule

bind adc_serial_port adc_sp_checker #(.RESULT_W(RESULT_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  localparam int W   = 32;
  localparam int DIV = 8;
  localparam int H   = DIV / 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs_n = 1'b1;
  logic         sck_in = 1'b0;
  logic         sck_internal = 1'b0;
  logic         conv_done = 1'b0;
  logic [W-1:0] result_in = '0;
  logic sdo, sdo_oe, sck_out, sck_oe, conv_start;

  int errs = 0, checks = 0, starts = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_serial_port #(.RESULT_W(W), .SCK_DIV(DIV)) i_adc_serial_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck_in(sck_in),
    .sck_internal(sck_internal), .conv_done(conv_done), .result_in(result_in),
    .sdo(sdo), .sdo_oe(sdo_oe), .sck_out(sck_out), .sck_oe(sck_oe),
    .conv_start(conv_start)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: 0 converting, 1 sleep, 2 data output.
  int   m_state = 0;
  int   m_ph = 0;
  logic m_q[$];
  logic m_sck = 1'b0, m_prev = 1'b0, m_prev_cs = 1'b1, m_start = 1'b1;

  always @(posedge clk) begin : model
    logic eff, rise, fall, csr, act, nstart;
    if (rst) begin
      m_state = 0; m_q.delete(); m_ph = 0; m_sck = 1'b0;
      m_prev = 1'b0; m_prev_cs = 1'b1; m_start = 1'b1;
    end else begin
      eff    = sck_internal ? m_sck : sck_in;
      rise   = eff && !m_prev;
      fall   = !eff && m_prev;
      csr    = cs_n && !m_prev_cs;
      act    = (m_state == 2) && !cs_n && sck_internal;
      nstart = 1'b0;
      if (m_state == 0) begin
        if (conv_done) begin
          m_q.delete();
          for (int i = W - 1; i >= 0; i--) m_q.push_back(result_in[i]);
          m_state = 1;
        end
      end else if (m_state == 1) begin
        if (!cs_n && (sck_internal || rise)) m_state = 2;
      end else begin
        if (csr) begin
          m_state = 0; m_q.delete(); nstart = 1'b1;
        end else if (fall) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin m_state = 0; nstart = 1'b1; end
        end
      end
      if (act) begin m_ph++; m_sck = ((m_ph / H) % 2) == 1; end
      else begin m_ph = 0; m_sck = 1'b0; end
      m_prev = eff; m_prev_cs = cs_n; m_start = nstart;
    end
  end

  always @(negedge clk) begin : compare
    logic exp_sdo;
    if (!rst && !done) begin
      exp_sdo = (m_state == 0) ? 1'b1 : (m_state == 1) ? 1'b0 :
                ((m_q.size() > 0) ? m_q[0] : 1'b0);
      check(sdo_oe == !cs_n, "R2 sdo_oe vs model", W'(sdo_oe), W'(!cs_n));
      check(sck_out == m_sck, "R8 sck_out vs model", W'(sck_out), W'(m_sck));
      check(sck_oe == sck_internal, "R8 sck_oe", W'(sck_oe), W'(sck_internal));
      check(conv_start == m_start, "R11 conv_start vs model", W'(conv_start), W'(m_start));
      if (!cs_n) check(sdo == exp_sdo, "R5 sdo vs model", W'(sdo), W'(exp_sdo));
      if (conv_start) starts++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic pulse_done(input logic [W-1:0] v);
    result_in = v; conv_done = 1'b1; step(1); conv_done = 1'b0;
  endtask

  task automatic ext_bits(input int n, output logic [W-1:0] got);
    got = '0;
    for (int k = 0; k < n; k++) begin
      sck_in = 1'b1; step(2);
      got[W-1-k] = sdo;
      sck_in = 1'b0; step(2);
    end
  endtask

  task automatic int_read(output logic [W-1:0] got, output int nbits, output bit per_ok);
    logic p = 1'b0;
    int   last = -1;
    got = '0; nbits = 0; per_ok = 1'b1;
    cs_n = 1'b0;
    for (int t = 0; t < W * DIV + 40 && nbits < W; t++) begin
      step(1);
      if (sck_out && !p) begin
        got[W-1-nbits] = sdo;
        nbits++;
        if (last >= 0 && (t - last) != DIV) per_ok = 1'b0;
        last = t;
      end
      p = sck_out;
    end
    step(DIV);
  endtask

  initial begin
    logic [W-1:0] got;
    int s0, nb;
    bit pok;

    step(3);
    check(conv_start == 1'b1, "R1 conv_start in reset", W'(conv_start), W'(1));
    check(sck_out == 1'b0, "R1 sck_out in reset", W'(sck_out), W'(0));
    rst = 1'b0; step(1);
    check(conv_start == 1'b0, "R1 conv_start after reset", W'(conv_start), W'(0));
    cs_n = 1'b0; step(1);
    check(sdo == 1'b1, "R1 converting after reset", W'(sdo), W'(1));
    check(sdo_oe == 1'b1, "R2 enabled with cs low", W'(sdo_oe), W'(1));

    // R3: strobe latches, flag goes ready
    cs_n = 1'b1; step(1);
    check(sdo_oe == 1'b0, "R2 released with cs high", W'(sdo_oe), W'(0));
    pulse_done(32'hA5C3_0F96);
    cs_n = 1'b0; step(1);
    check(sdo == 1'b0, "R3 sleep flag low", W'(sdo), W'(0));

    // R4: clock edges with cs high do not start output
    cs_n = 1'b1;
    for (int i = 0; i < 3; i++) begin sck_in = 1'b1; step(2); sck_in = 1'b0; step(2); end
    cs_n = 1'b0; step(2);
    check(sdo == 1'b0, "R4 still sleeping", W'(sdo), W'(0));

    // R5/R6: full external read
    s0 = starts;
    ext_bits(W, got);
    check(got == 32'hA5C3_0F96, "R5 word MSB first", got, 32'hA5C3_0F96);
    step(1);
    check(starts == s0 + 1, "R6 start pulse after last bit", W'(starts), W'(s0 + 1));
    check(sdo == 1'b1, "R6 converting again", W'(sdo), W'(1));

    // R10: strobe during sleep ignored
    pulse_done(32'h1234_5678);
    pulse_done(32'hFFFF_0000);
    ext_bits(W, got);
    check(got == 32'h1234_5678, "R10 sleep strobe ignored", got, 32'h1234_5678);

    // R7: cancel partway through
    pulse_done(32'h8000_0001);
    ext_bits(5, got);
    s0 = starts;
    cs_n = 1'b1; step(3);
    check(starts == s0 + 1, "R7 abort start pulse", W'(starts), W'(s0 + 1));
    cs_n = 1'b0; step(1);
    check(sdo == 1'b1, "R7 back to converting", W'(sdo), W'(1));
    pulse_done(32'h0F0F_F0F0);
    ext_bits(W, got);
    check(got == 32'h0F0F_F0F0, "R7 next word complete", got, 32'h0F0F_F0F0);

    // R8/R9: internal clock
    sck_internal = 1'b1; cs_n = 1'b1;
    pulse_done(32'hDEAD_BEEF);
    step(DIV * 2);
    check(sck_out == 1'b0, "R8 idle while cs high", W'(sck_out), W'(0));
    s0 = starts;
    int_read(got, nb, pok);
    check(nb == W, "R9 bit count", W'(nb), W'(W));
    check(got == 32'hDEAD_BEEF, "R9 internal word", got, 32'hDEAD_BEEF);
    check(pok == 1'b1, "R8 period of SCK_DIV", W'(pok), W'(1));
    check(starts == s0 + 1, "R6 internal end pulse", W'(starts), W'(s0 + 1));

    // R7/R8: cancel in internal mode
    cs_n = 1'b1;
    pulse_done(32'h5555_AAAA);
    cs_n = 1'b0; step(21);
    s0 = starts;
    cs_n = 1'b1; step(2);
    check(sck_out == 1'b0, "R8 stops after cs high", W'(sck_out), W'(0));
    check(starts == s0 + 1, "R7 internal abort", W'(starts), W'(s0 + 1));
    step(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule